// File: doc/BRIEF.md
# Pop-Free Mute and Soft-Start Sequencer

This block sits in the digital path of a stereo audio converter. It decides what the downstream converter sees, so that no audible step reaches the speaker. It drives two things: a DC bias code that stands for the analog rest level of the outputs, and a gain that it applies to every left/right sample pair. After power comes up it waits for the clock monitor to report a good clock. It then raises the bias code in a straight line from zero to the quiet level. Only after that does it open the audio, one small gain step per sample, so that the fade-in lasts a fixed number of sample periods whatever the sample rate is.

A clock fault is reported either as a level (`clk_ok` low) or as a one-cycle event (`clk_lost`). A fault while the bias is still rising freezes the bias where it stands. A fault while audio is playing or fading in cuts the data to exactly zero at once, and the bias stays at the quiet level. When the clock recovers, the fade-in starts again from silence. Dropping `pwr_ok` sends everything back to zero from any state. The whole sequence then repeats.

Top module: `mute_softstart_seq`

## Requirements
- R1: While `pwr_ok` is low, and out of reset, the state is OFF (code 0), `bias_code` is 0 and both outputs are 0. A drop of `pwr_ok` in any state gives this result one clock later.
- R2: State codes are OFF=0, BIAS_RAMP=1, BIAS_HOLD=2, FADE_IN=3, PLAY=4, MUTED=5. A powered block stays in OFF until a cycle with `clk_ok` high and `clk_lost` low, and then moves to BIAS_RAMP.
- R3: In BIAS_RAMP with a good clock, each `smp_stb` adds BIAS_STEP (16) to `bias_code`, clamped at BIAS_QUIET (1966). The strobe that reaches the clamp moves the state to FADE_IN.
- R4: A clock fault (`clk_ok` low or `clk_lost` high) in BIAS_RAMP moves the state to BIAS_HOLD. There `bias_code` does not change and strobes have no effect. The first good-clock cycle returns the state to BIAS_RAMP.
- R5: In FADE_IN the gain after n strobes is floor(n*1024/RAMP_SAMPLES), with RAMP_SAMPLES = 960. The RAMP_SAMPLES-th strobe moves the state to PLAY.
- R6: Each output is loaded one clock after a strobe with (s*g + 512) >>> 10, clamped to the signed 24-bit range. Here s is the two's complement input and g is the gain held before that strobe. Between strobes the outputs hold.
- R7: In PLAY each output equals its input sample exactly, including -8388608 and 8388607.
- R8: A clock fault in FADE_IN or PLAY gives state MUTED with both outputs 0 one clock later, while `bias_code` stays at BIAS_QUIET. The outputs stay 0 in every state other than FADE_IN and PLAY.
- R9: The first good-clock cycle in MUTED moves the state to FADE_IN with the gain back at 0, so the next strobe produces 0 and the fade-in lasts RAMP_SAMPLES strobes again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwr_ok | input | 1 | Supply good; low forces the power-off state |
| clk_ok | input | 1 | Clock monitor reports a valid clock ratio |
| clk_lost | input | 1 | One-cycle pulse for any clock fault event |
| smp_stb | input | 1 | One-cycle strobe per stereo sample period |
| in_left | input | 24 | Left input sample, two's complement |
| in_right | input | 24 | Right input sample, two's complement |
| out_left | output | 24 | Gained left sample |
| out_right | output | 24 | Gained right sample |
| bias_code | output | 12 | Digital code for the output DC bias level |
| seq_state | output | 3 | Sequencer state code |

## Verification
Every result of this block is registered once. State, bias code and gained samples all change on the rising edge that sees the strobe or fault, and are visible from that edge on. The bench drives inputs on the falling edge and updates its behavioural model at the rising edge from the same inputs. It compares state, bias and both outputs at the next falling edge, half a cycle after the design has updated. Directed checks placed right after a strobe, a fault pulse or a power change therefore land exactly one clock after the causing edge. This covers the rounding at half gain, the clamp of the bias code and the exact handover from fade-in to playback.

// File: rtl/mss_pkg.sv
package mss_pkg;

    typedef enum logic [2:0] {
        ST_OFF       = 3'd0,
        ST_BIAS_RAMP = 3'd1,
        ST_BIAS_HOLD = 3'd2,
        ST_FADE_IN   = 3'd3,
        ST_PLAY      = 3'd4,
        ST_MUTED     = 3'd5
    } seq_state_e;

endpackage

// File: rtl/mss_ctrl.sv
module mss_ctrl
    import mss_pkg::*;
#(
    parameter int BIAS_W     = 12,
    parameter int BIAS_STEP  = 16,
    parameter int BIAS_QUIET = 1966
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pwr_ok,
    input  logic              clk_ok,
    input  logic              clk_lost,
    input  logic              smp_stb,
    input  logic              gain_full,
    output seq_state_e        state_o,
    output logic [BIAS_W-1:0] bias_o,
    output logic              gain_adv,
    output logic              gain_clr
);

    localparam int SUM_W = BIAS_W + 1;

    typedef struct packed {
        seq_state_e        st;
        logic [BIAS_W-1:0] bias;
    } ctrl_t;

    ctrl_t             cur_q, cur_d;
    logic              clk_bad;
    logic [SUM_W-1:0]  bias_sum;

    always_comb begin
        clk_bad  = clk_lost || !clk_ok;
        bias_sum = {1'b0, cur_q.bias} + SUM_W'(BIAS_STEP);
        gain_adv = pwr_ok && !clk_bad && smp_stb && (cur_q.st == ST_FADE_IN);
        gain_clr = !pwr_ok || clk_bad ||
                   !((cur_q.st == ST_FADE_IN) || (cur_q.st == ST_PLAY));
        cur_d    = cur_q;
        if (!pwr_ok) begin
            cur_d.st   = ST_OFF;
            cur_d.bias = '0;
        end else begin
            unique case (cur_q.st)
                ST_OFF: begin
                    if (!clk_bad) cur_d.st = ST_BIAS_RAMP;
                end
                ST_BIAS_RAMP: begin
                    if (clk_bad) begin
                        cur_d.st = ST_BIAS_HOLD;
                    end else if (smp_stb) begin
                        if (bias_sum >= SUM_W'(BIAS_QUIET)) begin
                            cur_d.bias = BIAS_W'(BIAS_QUIET);
                            cur_d.st   = ST_FADE_IN;
                        end else begin
                            cur_d.bias = bias_sum[BIAS_W-1:0];
                        end
                    end
                end
                ST_BIAS_HOLD: begin
                    if (!clk_bad) cur_d.st = ST_BIAS_RAMP;
                end
                ST_FADE_IN: begin
                    if (clk_bad)        cur_d.st = ST_MUTED;
                    else if (gain_full) cur_d.st = ST_PLAY;
                end
                ST_PLAY: begin
                    if (clk_bad) cur_d.st = ST_MUTED;
                end
                ST_MUTED: begin
                    if (!clk_bad) cur_d.st = ST_FADE_IN;
                end
                default: cur_d.st = ST_OFF;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q.st   <= ST_OFF;
            cur_q.bias <= '0;
        end else begin
            cur_q <= cur_d;
        end
    end

    assign state_o = cur_q.st;
    assign bias_o  = cur_q.bias;

    // R1: power loss clears the bias and the state
    p_unpowered_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !pwr_ok |=> (cur_q.bias == '0 && cur_q.st == ST_OFF));

    // R3: the bias never passes the quiet level
    p_bias_cap_r3: assert property (@(posedge clk) disable iff (!rst_n)
        cur_q.bias <= BIAS_W'(BIAS_QUIET));

    // R3: the fade-in only runs on a settled bias
    p_fade_on_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_q.st == ST_FADE_IN || cur_q.st == ST_PLAY || cur_q.st == ST_MUTED)
        |-> cur_q.bias == BIAS_W'(BIAS_QUIET));

    // R4: a fault during the bias ramp freezes it
    p_ramp_to_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_q.st == ST_BIAS_RAMP && pwr_ok && (clk_lost || !clk_ok))
        |=> (cur_q.st == ST_BIAS_HOLD && $stable(cur_q.bias)));

    // R4: the held bias does not move
    p_hold_freeze_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_q.st == ST_BIAS_HOLD && pwr_ok) |=> $stable(cur_q.bias));

endmodule

// File: rtl/mss_gain.sv
module mss_gain #(
    parameter int FRAC_W       = 10,
    parameter int RAMP_SAMPLES = 960
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            adv,
    input  logic            clr,
    output logic [FRAC_W:0] gain_o,
    output logic            full_o
);

    // One strobe adds UNITY/RAMP_SAMPLES of gain; requires UNITY < 2*RAMP_SAMPLES.
    localparam int UNITY  = 1 << FRAC_W;
    localparam int GAIN_W = FRAC_W + 1;
    localparam int REM_W  = $clog2(2 * RAMP_SAMPLES + UNITY + 1);

    typedef struct packed {
        logic [GAIN_W-1:0] g;
        logic [REM_W-1:0]  rem;
    } gain_t;

    gain_t             cur_q, cur_d;
    logic [REM_W-1:0]  acc;
    logic [REM_W-1:0]  rem_nx;
    logic [1:0]        inc;
    logic [GAIN_W-1:0] g_nx;

    always_comb begin
        acc = cur_q.rem + REM_W'(UNITY);
        if (acc >= REM_W'(2 * RAMP_SAMPLES)) begin
            inc    = 2'd2;
            rem_nx = acc - REM_W'(2 * RAMP_SAMPLES);
        end else if (acc >= REM_W'(RAMP_SAMPLES)) begin
            inc    = 2'd1;
            rem_nx = acc - REM_W'(RAMP_SAMPLES);
        end else begin
            inc    = 2'd0;
            rem_nx = acc;
        end
        g_nx   = cur_q.g + GAIN_W'(inc);
        full_o = adv && (g_nx == GAIN_W'(UNITY));
        cur_d  = cur_q;
        if (clr) begin
            cur_d.g   = '0;
            cur_d.rem = '0;
        end else if (adv) begin
            cur_d.g   = g_nx;
            cur_d.rem = rem_nx;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q.g   <= '0;
            cur_q.rem <= '0;
        end else begin
            cur_q <= cur_d;
        end
    end

    assign gain_o = cur_q.g;

    // R5: gain bounded by unity, remainder by the ramp length
    p_gain_cap_r5: assert property (@(posedge clk) disable iff (!rst_n)
        cur_q.g <= GAIN_W'(UNITY) && cur_q.rem < REM_W'(RAMP_SAMPLES));

    // R5: the gain never falls during a step
    p_gain_rise_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && !clr) |=> cur_q.g >= $past(cur_q.g));

    // R9: a clear restarts the ramp from silence
    p_clear_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (cur_q.g == '0 && cur_q.rem == '0));

endmodule

// File: rtl/mss_scale.sv
module mss_scale #(
    parameter int DATA_W = 24,
    parameter int FRAC_W = 10
) (
    input  logic [DATA_W-1:0] smp_i,
    input  logic [FRAC_W:0]   gain_i,
    output logic [DATA_W-1:0] smp_o
);

    localparam int PROD_W = DATA_W + FRAC_W + 2;
    localparam int SHR_W  = PROD_W - FRAC_W;
    localparam logic signed [PROD_W-1:0] HALF  = PROD_W'(1) << (FRAC_W - 1);
    localparam logic signed [SHR_W-1:0]  MAX_V = {3'b000, {(DATA_W-1){1'b1}}};
    localparam logic signed [SHR_W-1:0]  MIN_V = ~MAX_V;

    logic signed [PROD_W-1:0] prod;
    logic signed [PROD_W-1:0] rounded;
    logic signed [SHR_W-1:0]  shr;
    logic signed [SHR_W-1:0]  sat;

    always_comb begin
        prod    = $signed({{(FRAC_W+2){smp_i[DATA_W-1]}}, smp_i}) *
                  $signed({{(DATA_W+1){1'b0}}, gain_i});
        rounded = prod + HALF;
        shr     = $signed(SHR_W'(rounded >>> FRAC_W));
        if (shr > MAX_V)      sat = MAX_V;
        else if (shr < MIN_V) sat = MIN_V;
        else                  sat = shr;
        smp_o   = sat[DATA_W-1:0];
    end

endmodule

// File: rtl/mute_softstart_seq.sv
module mute_softstart_seq
    import mss_pkg::*;
#(
    parameter int DATA_W       = 24,
    parameter int FRAC_W       = 10,
    parameter int RAMP_SAMPLES = 960,
    parameter int BIAS_W       = 12,
    parameter int BIAS_STEP    = 16,
    parameter int BIAS_QUIET   = 1966
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pwr_ok,
    input  logic              clk_ok,
    input  logic              clk_lost,
    input  logic              smp_stb,
    input  logic [DATA_W-1:0] in_left,
    input  logic [DATA_W-1:0] in_right,
    output logic [DATA_W-1:0] out_left,
    output logic [DATA_W-1:0] out_right,
    output logic [BIAS_W-1:0] bias_code,
    output logic [2:0]        seq_state
);

    localparam int CH = 2;

    typedef struct packed {
        logic [CH-1:0][DATA_W-1:0] smp;
    } out_t;

    seq_state_e         seq_st;
    logic               gain_adv, gain_clr, gain_full;
    logic [FRAC_W:0]    gain;
    logic [DATA_W-1:0]  ch_in     [CH];
    logic [DATA_W-1:0]  ch_scaled [CH];
    out_t               out_q, out_d;

    assign ch_in[0] = in_left;
    assign ch_in[1] = in_right;

    mss_ctrl #(
        .BIAS_W    (BIAS_W),
        .BIAS_STEP (BIAS_STEP),
        .BIAS_QUIET(BIAS_QUIET)
    ) ctrl_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .pwr_ok   (pwr_ok),
        .clk_ok   (clk_ok),
        .clk_lost (clk_lost),
        .smp_stb  (smp_stb),
        .gain_full(gain_full),
        .state_o  (seq_st),
        .bias_o   (bias_code),
        .gain_adv (gain_adv),
        .gain_clr (gain_clr)
    );

    mss_gain #(
        .FRAC_W      (FRAC_W),
        .RAMP_SAMPLES(RAMP_SAMPLES)
    ) gain_i (
        .clk   (clk),
        .rst_n (rst_n),
        .adv   (gain_adv),
        .clr   (gain_clr),
        .gain_o(gain),
        .full_o(gain_full)
    );

    for (genvar c = 0; c < CH; c++) begin : g_chan
        mss_scale #(
            .DATA_W(DATA_W),
            .FRAC_W(FRAC_W)
        ) scale_i (
            .smp_i (ch_in[c]),
            .gain_i(gain),
            .smp_o (ch_scaled[c])
        );
    end

    always_comb begin
        out_d = out_q;
        for (int c = 0; c < CH; c++) begin
            if (gain_clr)     out_d.smp[c] = '0;
            else if (smp_stb) out_d.smp[c] = ch_scaled[c];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) out_q <= '0;
        else        out_q <= out_d;
    end

    assign out_left  = out_q.smp[0];
    assign out_right = out_q.smp[1];
    assign seq_state = seq_st;

    // R8: silent data whenever audio is not enabled
    p_quiet_out_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !(seq_st == ST_FADE_IN || seq_st == ST_PLAY) |-> out_q == '0);

    // R8: a fault while audible mutes at once and keeps the bias
    p_fault_mute_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (pwr_ok && (clk_lost || !clk_ok) && (seq_st == ST_FADE_IN || seq_st == ST_PLAY))
        |=> (seq_st == ST_MUTED && out_q == '0 && bias_code == BIAS_W'(BIAS_QUIET)));

    // R7: playback passes the sample unchanged
    p_play_unity_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_st == ST_PLAY && smp_stb && pwr_ok && clk_ok && !clk_lost)
        |=> (out_left == $past(in_left) && out_right == $past(in_right)));

    // R6: outputs hold between strobes
    p_hold_between_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_st == ST_PLAY && !smp_stb && pwr_ok && clk_ok && !clk_lost)
        |=> $stable(out_q));

    // R9: recovery from mute restarts the fade-in
    p_recover_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_st == ST_MUTED && pwr_ok && clk_ok && !clk_lost) |=> seq_st == ST_FADE_IN);

endmodule

// File: tb/mute_softstart_seq_tb_top.sv
module mute_softstart_seq_tb_top;

    localparam int DW    = 24;
    localparam int FW    = 10;
    localparam int RL    = 960;
    localparam int BW    = 12;
    localparam int BSTEP = 16;
    localparam int BQ    = 1966;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          pwr_ok = 1'b0;
    logic          clk_ok = 1'b0;
    logic          clk_lost = 1'b0;
    logic          smp_stb = 1'b0;
    logic [DW-1:0] in_left = '0;
    logic [DW-1:0] in_right = '0;
    logic [DW-1:0] out_left, out_right;
    logic [BW-1:0] bias_code;
    logic [2:0]    seq_state;

    int n_checks = 0;
    int n_errors = 0;
    bit done = 1'b0;

    // behavioural reference state
    int m_st = 0, m_bias = 0, m_n = 0, m_ol = 0, m_or = 0;

    always #4 clk = ~clk;

    mute_softstart_seq #(
        .DATA_W(DW), .FRAC_W(FW), .RAMP_SAMPLES(RL),
        .BIAS_W(BW), .BIAS_STEP(BSTEP), .BIAS_QUIET(BQ)
    ) dut_i (
        .clk(clk), .rst_n(rst_n), .pwr_ok(pwr_ok), .clk_ok(clk_ok),
        .clk_lost(clk_lost), .smp_stb(smp_stb),
        .in_left(in_left), .in_right(in_right),
        .out_left(out_left), .out_right(out_right),
        .bias_code(bias_code), .seq_state(seq_state)
    );

    function automatic int apply_gain(int s, int g);
        longint p;
        p = longint'(s) * longint'(g) + 512;
        p = p >>> 10;
        if (p > 8388607)  p = 8388607;
        if (p < -8388608) p = -8388608;
        return int'(p);
    endfunction

    function automatic int gain_after(int n);
        return (n * 1024) / RL;
    endfunction

    function automatic string tag_of(int st);
        case (st)
            0: return "R1";
            1: return "R3";
            2: return "R4";
            3: return "R5";
            4: return "R7";
            default: return "R8";
        endcase
    endfunction

    task automatic check(string tag, string what, int act, int exp);
        n_checks++;
        if (act != exp) begin
            n_errors++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    // reference model, advanced on the same edge as the design
    always @(posedge clk) begin
        bit bad;
        int sl, sr;
        if (!rst_n) begin
            m_st = 0; m_bias = 0; m_n = 0; m_ol = 0; m_or = 0;
        end else begin
            bad = clk_lost || !clk_ok;
            sl  = int'($signed(in_left));
            sr  = int'($signed(in_right));
            if (!pwr_ok) begin
                m_st = 0; m_bias = 0; m_n = 0; m_ol = 0; m_or = 0;
            end else begin
                case (m_st)
                    0: if (!bad) m_st = 1;
                    1: begin
                        if (bad) m_st = 2;
                        else if (smp_stb) begin
                            m_bias += BSTEP;
                            if (m_bias >= BQ) begin m_bias = BQ; m_st = 3; m_n = 0; end
                        end
                    end
                    2: if (!bad) m_st = 1;
                    3: begin
                        if (bad) begin m_st = 5; m_n = 0; m_ol = 0; m_or = 0; end
                        else if (smp_stb) begin
                            m_ol = apply_gain(sl, gain_after(m_n));
                            m_or = apply_gain(sr, gain_after(m_n));
                            m_n++;
                            if (m_n == RL) m_st = 4;
                        end
                    end
                    4: begin
                        if (bad) begin m_st = 5; m_ol = 0; m_or = 0; end
                        else if (smp_stb) begin m_ol = sl; m_or = sr; end
                    end
                    default: if (!bad) begin m_st = 3; m_n = 0; end
                endcase
            end
        end
    end

    // every-clock comparison, half a cycle after the design updates
    always @(negedge clk) begin
        if (rst_n && !done) begin
            check(tag_of(m_st), "state", int'(seq_state), m_st);
            check(tag_of(m_st), "bias", int'(bias_code), m_bias);
            check("R6", "left", int'($signed(out_left)), m_ol);
            check("R6", "right", int'($signed(out_right)), m_or);
        end
    end

    task automatic strobe(input int l, input int r);
        in_left  = l[DW-1:0];
        in_right = r[DW-1:0];
        smp_stb  = 1'b1;
        @(negedge clk);
        smp_stb  = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    task automatic strobe_rand(input int count);
        for (int i = 0; i < count; i++)
            strobe(int'($urandom) >>> 8, int'($urandom) >>> 8);
    endtask

    task automatic pulse_lost();
        clk_lost = 1'b1;
        @(negedge clk);
    endtask

    initial begin
        int held;
        @(negedge clk);
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", "reset state", int'(seq_state), 0);
        check("R1", "reset bias", int'(bias_code), 0);
        check("R1", "reset out", int'(out_left), 0);

        pwr_ok = 1'b1;
        strobe_rand(4);
        check("R2", "waits for clock", int'(seq_state), 0);

        clk_ok = 1'b1;
        @(negedge clk);
        check("R2", "starts bias ramp", int'(seq_state), 1);

        strobe_rand(40);
        check("R3", "bias after 40 strobes", int'(bias_code), 640);

        pulse_lost();
        check("R4", "fault freezes ramp", int'(seq_state), 2);
        clk_lost = 1'b0;
        clk_ok   = 1'b0;
        strobe_rand(5);
        check("R4", "held bias", int'(bias_code), 640);
        check("R4", "held state", int'(seq_state), 2);
        clk_ok = 1'b1;
        @(negedge clk);
        strobe_rand(82);
        check("R3", "bias before clamp", int'(bias_code), 1952);
        check("R3", "still ramping", int'(seq_state), 1);
        strobe_rand(1);
        check("R3", "bias clamped", int'(bias_code), BQ);
        check("R3", "fade-in begins", int'(seq_state), 3);

        strobe_rand(480);
        strobe(1001, -1001);
        check("R6", "half gain left", int'($signed(out_left)), 501);
        check("R6", "half gain right", int'($signed(out_right)), -500);
        repeat (3) @(negedge clk);
        check("R6", "held between strobes", int'($signed(out_left)), 501);

        pulse_lost();
        check("R8", "muted state", int'(seq_state), 5);
        check("R8", "muted left", int'(out_left), 0);
        check("R8", "bias kept", int'(bias_code), BQ);
        clk_lost = 1'b0;
        @(negedge clk);
        check("R9", "fade restarts", int'(seq_state), 3);
        strobe(1000000, -1000000);
        check("R9", "first sample silent", int'(out_left), 0);
        strobe_rand(958);
        check("R5", "one strobe short", int'(seq_state), 3);
        strobe_rand(1);
        check("R5", "reaches playback", int'(seq_state), 4);
        strobe(-8388608, 8388607);
        check("R7", "min passes", int'($signed(out_left)), -8388608);
        check("R7", "max passes", int'($signed(out_right)), 8388607);
        strobe_rand(10);
        held = int'($signed(out_right));

        clk_ok = 1'b0;
        @(negedge clk);
        check("R8", "level fault mutes", int'(seq_state), 5);
        check("R8", "level fault zero", int'(out_right), (held == 0) ? 0 : 0);
        clk_ok = 1'b1;
        @(negedge clk);
        strobe_rand(50);

        pwr_ok = 1'b0;
        @(negedge clk);
        check("R1", "power loss state", int'(seq_state), 0);
        check("R1", "power loss bias", int'(bias_code), 0);
        check("R1", "power loss out", int'(out_left), 0);
        pwr_ok = 1'b1;
        @(negedge clk);
        check("R2", "power return ramps", int'(seq_state), 1);
        strobe_rand(20);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_checks++;
            n_errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    end

endmodule